// File: doc/BRIEF.md
# Lane Activity Mask Stack

This block tracks which lanes of a wide vector unit are enabled while the unit runs structured, non-looping branch code. It holds the live lane mask and a stack of saved lane sets, one per open branch level. A sequencer drives a small command port with three commands: open a branch with a per-lane condition vector, switch to the alternative path, and close the branch. Each command takes effect at one clock edge, and the new mask is on the output in the next cycle.

When a branch opens, the block saves the lanes that were enabled but failed the condition. When the alternative path starts, it enables exactly those waiting lanes and saves the lanes that ran the first path. When the branch closes, it merges the saved lanes back in. An idle flag shows when no lane is enabled, so the sequencer can skip a region. In pixel mode, closing the outermost branch with no lane left enabled first requests a null export and then requests termination of the wavefront. Opening more levels than the stack holds, or switching or closing with nothing open, is reported on an error strobe and changes nothing.

Top module: `exec_mask_stack`

## Requirements
- R1: While reset is asserted, the mask loads the value on `init_mask`, the depth goes to 0, and all strobes go low. Once reset is released, the mask keeps that value until a command arrives.
- R2: An open command (`cmd_op`=1) with depth below `DEPTH` sets the mask to the old mask AND `cmd_cond` and raises the depth by one. The new mask is visible in the cycle after the command.
- R3: A switch command (`cmd_op`=2) with depth above 0 sets the mask to the lanes that were enabled before the matching open command and failed its condition. The depth does not change.
- R4: A close command (`cmd_op`=3) with depth above 0 restores the mask that was live before the matching open command and lowers the depth by one.
- R5: Branches nest. Each close command restores the mask of its own level, and the inner levels do not change the outer levels' saved lanes.
- R6: `mask_idle` is high exactly when every bit of `exec_mask` is 0.
- R7: An open command at depth `DEPTH` pulses `err_overflow` high for one cycle, in the cycle after the command. The mask and the depth stay unchanged.
- R8: A switch or close command at depth 0 pulses `err_underflow` high for one cycle, in the cycle after the command. The mask and the depth stay unchanged.
- R9: When `pixel_mode` is high and a close command takes the depth from 1 to 0 with a result mask of zero, `null_export` pulses in the cycle after the command and `terminate` pulses in the cycle after that.
- R10: `null_export` and `terminate` stay low in each of these cases: pixel mode is off, the result mask is nonzero, or the close command leaves the depth above 0.
- R11: `cmd_op`=0 means no operation. While it is applied, the mask and the depth do not change and `cmd_cond` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_mask | input | LANES | Lane set loaded into the mask during reset |
| pixel_mode | input | 1 | Enables the null-export and terminate sequence |
| cmd_op | input | 2 | 0 none, 1 open, 2 switch, 3 close |
| cmd_cond | input | LANES | Per-lane condition for the open command |
| exec_mask | output | LANES | Live lane enable mask |
| mask_idle | output | 1 | High when no lane is enabled |
| nest_depth | output | $clog2(DEPTH+1) | Number of open branch levels |
| err_overflow | output | 1 | One-cycle strobe: open command refused |
| err_underflow | output | 1 | One-cycle strobe: switch or close command with no level open |
| null_export | output | 1 | One-cycle strobe requesting a null-target export |
| terminate | output | 1 | One-cycle strobe, one cycle after `null_export` |

## Verification
The assertions check several rules on every cycle:
- an accepted open command never enables a lane that was disabled before it;
- an accepted close command lowers the depth by exactly one;
- a refused command leaves the mask and the depth unchanged;
- the stack is never pushed when full or popped when empty;
- `terminate` only ever follows `null_export`.

Only the bench scenarios can show the exact lane sets. These are the lane sets that a switch command selects, the masks restored through two nested levels, and the cases where the pixel-mode sequence fires or must stay quiet.

// File: rtl/exmask_pkg.sv
`timescale 1ns/1ps
package exmask_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_IF    = 2'd1,
      OP_ELSE  = 2'd2,
      OP_ENDIF = 2'd3
   } mask_op_e;
endpackage

// File: rtl/exmask_alu.sv
`timescale 1ns/1ps
// Combinational lane-set arithmetic for the three branch commands.
module exmask_alu
   import exmask_pkg::*;
#(
   parameter int LANES = 64
) (
   input  mask_op_e           op,
   input  logic [LANES-1:0]   cur_mask,
   input  logic [LANES-1:0]   stack_top,
   input  logic [LANES-1:0]   cond,
   output logic [LANES-1:0]   next_mask,
   output logic [LANES-1:0]   save_val
);
   logic [LANES-1:0] taken;
   logic [LANES-1:0] merged;

   // Lanes that stay enabled inside the first path.
   assign taken  = cur_mask & cond;
   assign merged = cur_mask | stack_top;

   always_comb begin
      next_mask = cur_mask;
      save_val  = '0;
      unique case (op)
         OP_IF: begin
            next_mask = taken;
            // Enabled before the open command but failed the condition.
            save_val  = cur_mask ^ taken;
         end
         OP_ELSE: begin
            // Keep the first-path lanes, then enable only the waiting lanes.
            save_val  = cur_mask;
            next_mask = merged ^ cur_mask;
         end
         OP_ENDIF: begin
            next_mask = merged;
         end
         default: begin
            next_mask = cur_mask;
         end
      endcase
   end
endmodule

// File: rtl/exmask_lifo.sv
`timescale 1ns/1ps
// Stack of saved lane sets, one entry per open branch level.
module exmask_lifo #(
   parameter int LANES = 64,
   parameter int DEPTH = 8,
   localparam int DW = $clog2(DEPTH + 1),
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              rewrite,
   input  logic [LANES-1:0]  wdata,
   output logic [LANES-1:0]  top,
   output logic [DW-1:0]     level,
   output logic              full,
   output logic              empty
);
   logic [DW-1:0] cnt_q;
   logic [DW-1:0] top_ptr;

   assign top_ptr = cnt_q - DW'(1);
   assign full    = (cnt_q == DW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign level   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (push) begin
         cnt_q <= cnt_q + DW'(1);
      end else if (pop) begin
         cnt_q <= cnt_q - DW'(1);
      end
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [LANES-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (push || rewrite) slot_q <= wdata;
         end
         assign top = empty ? '0 : slot_q;
      end else begin : g_array
         logic [LANES-1:0] mem_q [DEPTH];
         always_ff @(posedge clk) begin
            if (push)         mem_q[cnt_q[IW-1:0]]   <= wdata;
            else if (rewrite) mem_q[top_ptr[IW-1:0]] <= wdata;
         end
         assign top = empty ? '0 : mem_q[top_ptr[IW-1:0]];
      end
   endgenerate

   // R7
   no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R8
   no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop || rewrite) |-> !empty);
   // R7
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= DW'(DEPTH));
endmodule

// File: rtl/exmask_kill.sv
`timescale 1ns/1ps
// Pixel-mode sequence: a null export, then termination in the next cycle.
module exmask_kill (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic null_export,
   output logic terminate
);
   logic null_q;
   logic term_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         null_q <= 1'b0;
         term_q <= 1'b0;
      end else begin
         null_q <= fire;
         term_q <= null_q;
      end
   end

   assign null_export = null_q;
   assign terminate   = term_q;

   // R9
   term_after_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term_q |-> $past(null_q));
endmodule

// File: rtl/exec_mask_stack.sv
`timescale 1ns/1ps
module exec_mask_stack
   import exmask_pkg::*;
#(
   parameter int LANES = 64,
   parameter int DEPTH = 8,
   localparam int DW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANES-1:0]  init_mask,
   input  logic              pixel_mode,
   input  logic [1:0]        cmd_op,
   input  logic [LANES-1:0]  cmd_cond,
   output logic [LANES-1:0]  exec_mask,
   output logic              mask_idle,
   output logic [DW-1:0]     nest_depth,
   output logic              err_overflow,
   output logic              err_underflow,
   output logic              null_export,
   output logic              terminate
);
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("exec_mask_stack: LANES must be at least 1");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("exec_mask_stack: DEPTH must be at least 1");
      end
   endgenerate

   mask_op_e         op;
   logic [LANES-1:0] mask_q;
   logic [LANES-1:0] top;
   logic [LANES-1:0] alu_mask;
   logic [LANES-1:0] alu_save;
   logic [DW-1:0]    level;
   logic             full, empty;
   logic             do_if, do_else, do_endif, bad_if, bad_pop;
   logic             ovf_q, unf_q;
   logic             kill_fire;

   assign op       = mask_op_e'(cmd_op);
   assign do_if    = (op == OP_IF) && !full;
   assign do_else  = (op == OP_ELSE) && !empty;
   assign do_endif = (op == OP_ENDIF) && !empty;
   assign bad_if   = (op == OP_IF) && full;
   assign bad_pop  = ((op == OP_ELSE) || (op == OP_ENDIF)) && empty;

   exmask_alu #(.LANES(LANES)) u_alu (
      .op        (op),
      .cur_mask  (mask_q),
      .stack_top (top),
      .cond      (cmd_cond),
      .next_mask (alu_mask),
      .save_val  (alu_save)
   );

   exmask_lifo #(.LANES(LANES), .DEPTH(DEPTH)) u_lifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (do_if),
      .pop     (do_endif),
      .rewrite (do_else),
      .wdata   (alu_save),
      .top     (top),
      .level   (level),
      .full    (full),
      .empty   (empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= init_mask;
         ovf_q  <= 1'b0;
         unf_q  <= 1'b0;
      end else begin
         if (do_if || do_else || do_endif) mask_q <= alu_mask;
         ovf_q <= bad_if;
         unf_q <= bad_pop;
      end
   end

   assign kill_fire = pixel_mode && do_endif && (level == DW'(1)) && (alu_mask == '0);

   exmask_kill u_kill (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire        (kill_fire),
      .null_export (null_export),
      .terminate   (terminate)
   );

   assign exec_mask     = mask_q;
   assign mask_idle     = ~|mask_q;
   assign nest_depth    = level;
   assign err_overflow  = ovf_q;
   assign err_underflow = unf_q;

   // R2
   if_narrows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_IF && !full) |=> ((exec_mask & ~$past(exec_mask)) == '0));
   // R4
   endif_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ENDIF && !empty) |=> (nest_depth == $past(nest_depth) - DW'(1)));
   // R7
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow |-> (exec_mask == $past(exec_mask) && nest_depth == $past(nest_depth)));
   // R8
   unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_underflow |-> (exec_mask == $past(exec_mask) && nest_depth == $past(nest_depth)));
   // R11
   nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_NONE) |=> (exec_mask == $past(exec_mask)));
endmodule

// File: tb/exec_mask_stack_test.sv
`timescale 1ns/1ps
module exec_mask_stack_test;
   localparam int LANES = 64;
   localparam int DEPTH = 8;
   localparam int DW = $clog2(DEPTH + 1);
   localparam logic [63:0] ONES = {64{1'b1}};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [LANES-1:0] init_mask = ONES;
   logic             pixel_mode = 1'b0;
   logic [1:0]       cmd_op = 2'd0;
   logic [LANES-1:0] cmd_cond = '0;
   logic [LANES-1:0] exec_mask;
   logic             mask_idle;
   logic [DW-1:0]    nest_depth;
   logic             err_overflow, err_underflow, null_export, terminate;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   exec_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .init_mask(init_mask), .pixel_mode(pixel_mode),
      .cmd_op(cmd_op), .cmd_cond(cmd_cond), .exec_mask(exec_mask),
      .mask_idle(mask_idle), .nest_depth(nest_depth), .err_overflow(err_overflow),
      .err_underflow(err_underflow), .null_export(null_export), .terminate(terminate)
   );

   // Vector table: op, condition, expected mask, expected depth.
   localparam int NV = 12;
   localparam logic [1:0]  V_OP   [NV] = '{2'd1, 2'd1, 2'd2, 2'd3, 2'd2, 2'd1,
                                           2'd3, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3};
   localparam logic [63:0] V_COND [NV] = '{64'h00FF_00FF_00FF_00FF, 64'h0F0F_0F0F_0F0F_0F0F,
                                           64'h0, 64'h0, 64'h0, 64'hFFFF_0000_0000_0000,
                                           64'h0, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'h0,
                                           64'h0, 64'h0};
   localparam logic [63:0] V_MASK [NV] = '{64'h00FF_00FF_00FF_00FF, 64'h000F_000F_000F_000F,
                                           64'h00F0_00F0_00F0_00F0, 64'h00FF_00FF_00FF_00FF,
                                           64'hFF00_FF00_FF00_FF00, 64'hFF00_0000_0000_0000,
                                           64'hFF00_FF00_FF00_FF00, ONES, ONES, 64'h0,
                                           ONES, ONES};
   localparam int          V_DEP  [NV] = '{1, 2, 2, 1, 1, 2, 1, 0, 0, 1, 1, 0};
   localparam string       V_REQ  [NV] = '{"R2", "R5", "R3", "R4", "R3", "R5",
                                           "R5", "R4", "R11", "R6", "R3", "R4"};

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called at a negedge; returns at the next negedge with outputs updated.
   task automatic issue(input logic [1:0] op, input logic [63:0] c);
      cmd_op = op;
      cmd_cond = c;
      @(negedge clk);
      cmd_op = 2'd0;
      cmd_cond = '0;
   endtask

   task automatic do_reset(input logic [63:0] im, input logic pm);
      cmd_op = 2'd0;
      init_mask = im;
      pixel_mode = pm;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R1 reset state
      do_reset(ONES, 1'b0);
      check("R1 mask", exec_mask, ONES);
      check("R1 depth", 64'(nest_depth), 64'd0);
      check("R1 strobes", {60'd0, err_overflow, err_underflow, null_export, terminate}, 64'd0);

      for (int i = 0; i < NV; i++) begin
         issue(V_OP[i], V_COND[i]);
         check(V_REQ[i], exec_mask, V_MASK[i]);
         check(V_REQ[i], 64'(nest_depth), 64'(V_DEP[i]));
         check("R6 idle", 64'(mask_idle), 64'(V_MASK[i] == 64'h0));
      end

      // R7 overflow
      for (int i = 0; i < DEPTH; i++) issue(2'd1, ONES);
      check("R7 full depth", 64'(nest_depth), 64'(DEPTH));
      issue(2'd1, 64'h0);
      check("R7 overflow strobe", 64'(err_overflow), 64'd1);
      check("R7 mask kept", exec_mask, ONES);
      check("R7 depth kept", 64'(nest_depth), 64'(DEPTH));
      issue(2'd0, 64'h0);
      check("R7 strobe one cycle", 64'(err_overflow), 64'd0);
      for (int i = 0; i < DEPTH; i++) issue(2'd3, 64'h0);
      check("R4 unwound", 64'(nest_depth), 64'd0);

      // R8 underflow
      issue(2'd3, 64'h0);
      check("R8 endif underflow", 64'(err_underflow), 64'd1);
      check("R8 mask kept", exec_mask, ONES);
      issue(2'd2, 64'h0);
      check("R8 else underflow", 64'(err_underflow), 64'd1);
      check("R8 depth kept", 64'(nest_depth), 64'd0);
      issue(2'd0, 64'h0);
      check("R8 strobe one cycle", 64'(err_underflow), 64'd0);

      // R9 pixel mode, zero mask at the outermost close
      do_reset(64'h0, 1'b1);
      check("R1 init mask", exec_mask, 64'h0);
      issue(2'd1, ONES);
      issue(2'd1, ONES);
      issue(2'd3, 64'h0);
      check("R10 inner close quiet", 64'(null_export), 64'd0);
      issue(2'd3, 64'h0);
      check("R9 null export", 64'(null_export), 64'd1);
      check("R9 no early terminate", 64'(terminate), 64'd0);
      @(negedge clk);
      check("R9 terminate", 64'(terminate), 64'd1);
      check("R9 null one cycle", 64'(null_export), 64'd0);

      // R10 pixel mode off
      do_reset(64'h0, 1'b0);
      issue(2'd1, ONES);
      issue(2'd3, 64'h0);
      check("R10 mode off", 64'(null_export), 64'd0);
      @(negedge clk);
      check("R10 mode off term", 64'(terminate), 64'd0);

      // R10 nonzero result
      do_reset(ONES, 1'b1);
      issue(2'd1, 64'h0);
      check("R6 idle in region", 64'(mask_idle), 64'd1);
      issue(2'd3, 64'h0);
      check("R10 nonzero", 64'(null_export), 64'd0);
      check("R4 restored", exec_mask, ONES);
      @(negedge clk);
      check("R10 nonzero term", 64'(terminate), 64'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule